// File: doc/BRIEF.md
# Staggered quad PWM generator

This block produces four pulse-width-modulated drive signals for inductive low-side loads. All four share one 16-step period counter, which advances once per `step_tick` pulse. Each channel reads its own 4-bit duty code. A code of N gives N steps of high time per period. Code 0 keeps the drive low for the whole period.

Two mechanisms keep the channels from switching together. The even-indexed channels (0 and 2) place their high time at the start of the period. The odd-indexed channels (1 and 3) place theirs at the end. In addition, channel k updates its internal PWM level k+1 clock cycles after the step tick. As a result, no two channels ever change level in the same clock cycle, and the combined current slope seen by the supply stays smaller.

Other conditions gate the drive outputs without disturbing the PWM timing:
- An overcurrent comparator input blanks its channel for the rest of the current period.
- An undervoltage input forces every drive low while it is asserted.

Single-cycle rise and fall strobes of each internal PWM signal are provided for the diagnostic sampling logic.

Top module: `stag_pwm_quad`

## Requirements
- R1: The period counter resets to 0, advances by one on each clock cycle in which `step_tick` is 1, and wraps from 15 to 0. It holds its value when `step_tick` is 0.
- R2: With active code N (1..15), the drive of channels 0 and 2 is high at counter values 0..N-1. The drive of channels 1 and 3 is high at counter values 16-N..15. Channel k takes its code from `duty_code[4k+3:4k]`.
- R3: A channel whose active code is 0 keeps its drive low for the whole period.
- R4: Channel k updates its internal PWM level exactly k+1 clock cycles after a `step_tick` pulse. Given `step_tick` pulses at least 5 cycles apart, no two rise/fall strobes are ever high in the same cycle.
- R5: A channel loads a new code only at its update that follows the counter wrapping to 0. A change of `duty_code` in mid-period has no effect on the drive until that boundary.
- R6: `oc_trip[k]` is synchronized through two flip-flops. Once it is seen high, `drive[k]` goes low and stays low until the channel's next period boundary. The other channels are unaffected.
- R7: While `uv_off` is 1, all drive outputs are 0 in the same cycle. Counter, codes and blanking state are kept, so the drive resumes the programmed pattern as soon as `uv_off` returns to 0.
- R8: `pwm_rise[k]` and `pwm_fall[k]` are high for exactly one cycle at each internal level change. There is exactly one rise and one fall per channel per period, also for code 0: in that case the internal signal runs a one-step pulse while the drive stays low.
- R9: While `rst_n` is 0 at a clock edge, all outputs, the counter and all active codes are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_tick | input | 1 | One-cycle pulse that advances the period counter |
| uv_off | input | 1 | Supply undervoltage; forces all drives low |
| duty_code | input | 16 | Four 4-bit duty codes, channel k in bits 4k+3:4k |
| oc_trip | input | 4 | Asynchronous overcurrent comparator outputs, one per channel |
| drive | output | 4 | Gated drive signals to the power stage |
| pwm_rise | output | 4 | One-cycle strobe at each rising edge of the internal PWM |
| pwm_fall | output | 4 | One-cycle strobe at each falling edge of the internal PWM |

## Verification
The hardest situation to reach from the ports is an overcurrent blank that must survive to the end of the period and then release exactly at the channel's own boundary update. The stimulus sets a known code, pulses the comparator input for a few cycles partway through the high window, and then steps the counter tick by tick. At every tick it compares the drive against a model that masks only the tripped channel until the wrap. The stimulus also changes codes in mid-period and holds every channel at code 0 for a full period. These two cases show that the boundary-only loading and the strobes of a zero-code channel still behave as required.

// File: rtl/qpwm_pkg.sv
// Package: shared constants and the PWM window function for the
// staggered quad PWM generator.
// Assumes: positions and widths are small non-negative integers.
package qpwm_pkg;

    parameter int unsigned DEF_NCH = 4;
    parameter int unsigned DEF_CW  = 4;

    // Decide whether the PWM level is high at a counter position.
    // An early channel is high for the first 'width' positions of the period.
    // A late channel is high for the last 'width' positions of the period.
    function automatic logic pwm_level(input int unsigned pos,
                                       input int unsigned width,
                                       input int unsigned period,
                                       input logic        late);
        logic lvl;
        if (late) begin
            lvl = (pos + width >= period);
        end else begin
            lvl = (pos < width);
        end
        return lvl;
    endfunction

endpackage

// File: rtl/qpwm_step_counter.sv
// Module: shared period counter.
// Advances once per step pulse and wraps from PERIOD-1 to 0.
// Assumes: the step pulse is synchronous to clk.
module qpwm_step_counter #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] cnt
);

    // Purpose: count steps modulo 2**CW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/qpwm_sync.sv
// Module: multi-bit, bit-independent synchronizer chain.
// Each bit passes through STAGES flip-flops.
// Assumes: the bits are independent level signals (no bus coherence is needed).
module qpwm_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/qpwm_channel.sv
// Module: one PWM channel.
// It holds an active duty code that is loaded only at the period boundary.
// It produces the internal PWM level and its one-cycle edge strobes, and it
// keeps the overcurrent blanking latch.
// A late channel (LATE=1) places its high time at the end of the period.
// Code 0 runs a one-step internal pulse so that the strobes still occur,
// while the drive stays low.
// Assumes: 'upd' pulses once per counter step, after the counter has settled.
module qpwm_channel
    import qpwm_pkg::*;
#(
    parameter int unsigned CW   = 4,
    parameter logic        LATE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] code_in,
    input  logic          oc_seen,
    input  logic          uv_off,
    output logic          drive,
    output logic          rise,
    output logic          fall
);

    localparam int unsigned PERIOD = 1 << CW;

    logic [CW-1:0] act_q;
    logic          nz_q;
    logic          pwm_q;
    logic          blank_q;
    logic          at_start;
    logic [CW-1:0] code_eff;
    int unsigned   width_eff;
    logic          pwm_nx;

    // Purpose: choose the code for this step and compute the next PWM level.
    always_comb begin
        at_start  = (cnt == '0);
        code_eff  = at_start ? code_in : act_q;
        width_eff = (code_eff == '0) ? 32'd1 : 32'(code_eff);
        pwm_nx    = pwm_level(32'(cnt), width_eff, PERIOD, LATE);
    end

    // Purpose: update the level, the edge strobes and the boundary code load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            nz_q  <= 1'b0;
            pwm_q <= 1'b0;
            rise  <= 1'b0;
            fall  <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (upd) begin
                pwm_q <= pwm_nx;
                rise  <= pwm_nx & ~pwm_q;
                fall  <= ~pwm_nx & pwm_q;
                if (at_start) begin
                    act_q <= code_in;
                    nz_q  <= |code_in;
                end
            end
        end
    end

    // Purpose: overcurrent blanking; the latch is cleared at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_q <= 1'b0;
        end else if (upd && at_start) begin
            blank_q <= 1'b0;
        end else if (oc_seen) begin
            blank_q <= 1'b1;
        end
    end

    // Purpose: gate the internal level into the drive output.
    always_comb begin
        drive = pwm_q & nz_q & ~blank_q & ~uv_off;
    end

endmodule

// File: rtl/stag_pwm_quad.sv
// Module: staggered quad PWM generator (top).
// One shared period counter feeds NCH channels.
// Channel k updates k+1 cycles after each step tick, so that no two
// channels switch in the same cycle.
// Odd-indexed channels are time-mirrored (high at the end of the period).
// Assumes: step_tick pulses are at least NCH+1 cycles apart.
//          oc_trip is asynchronous; uv_off is a synchronous level.
module stag_pwm_quad
    import qpwm_pkg::*;
#(
    parameter int unsigned NCH = DEF_NCH,
    parameter int unsigned CW  = DEF_CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_tick,
    input  logic              uv_off,
    input  logic [NCH*CW-1:0] duty_code,
    input  logic [NCH-1:0]    oc_trip,
    output logic [NCH-1:0]    drive,
    output logic [NCH-1:0]    pwm_rise,
    output logic [NCH-1:0]    pwm_fall
);

    localparam int unsigned SYNC_STAGES = 2;

    logic [CW-1:0]  cnt_q;
    logic [NCH-1:0] tick_dly;
    logic [NCH-1:0] oc_seen;

    qpwm_step_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_tick),
        .cnt   (cnt_q)
    );

    qpwm_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_oc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (oc_trip),
        .q     (oc_seen)
    );

    // Purpose: delay line that staggers the channel update cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_dly <= '0;
        end else begin
            tick_dly <= {tick_dly[NCH-2:0], step_tick};
        end
    end

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            qpwm_channel #(
                .CW   (CW),
                .LATE (1'((k % 2) == 1))
            ) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .upd     (tick_dly[k]),
                .cnt     (cnt_q),
                .code_in (duty_code[k*CW +: CW]),
                .oc_seen (oc_seen[k]),
                .uv_off  (uv_off),
                .drive   (drive[k]),
                .rise    (pwm_rise[k]),
                .fall    (pwm_fall[k])
            );
        end
    endgenerate

endmodule

// File: rtl/stag_pwm_quad_chk.sv
// Checker: temporal properties of the staggered quad PWM generator.
// It is attached to the top module by the bind statement at the end of this file.
module stag_pwm_quad_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           step_tick,
    input logic           uv_off,
    input logic [CW-1:0]  cnt,
    input logic [NCH-1:0] drive,
    input logic [NCH-1:0] pwm_rise,
    input logic [NCH-1:0] pwm_fall
);

    // R1: the counter wraps from its last value to zero on a step.
    a_r1_counter_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_tick && (cnt == '1)) |=> (cnt == '0));

    // R1: the counter holds when there is no step.
    a_r1_counter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> $stable(cnt));

    // R4: at most one channel has an edge strobe in any cycle.
    a_r4_no_shared_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwm_rise | pwm_fall) <= 1);

    // R7: undervoltage forces every drive low.
    a_r7_uv_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_off |-> (drive == '0));

    // R8: a rise strobe never lasts two cycles.
    a_r8_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|pwm_rise) |=> ((pwm_rise & $past(pwm_rise)) == '0));

    // R8: a fall strobe never lasts two cycles.
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|pwm_fall) |=> ((pwm_fall & $past(pwm_fall)) == '0));

endmodule

bind stag_pwm_quad stag_pwm_quad_chk #(.NCH(NCH), .CW(CW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .uv_off    (uv_off),
    .cnt       (cnt_q),
    .drive     (drive),
    .pwm_rise  (pwm_rise),
    .pwm_fall  (pwm_fall)
);

// File: tb/stag_pwm_quad_tb_top.sv
// Testbench for stag_pwm_quad.
// A table of duty vectors is walked period by period, followed by directed
// tests for overcurrent, undervoltage, reset and code 0.
module stag_pwm_quad_tb_top;

    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{16'h8421, 16'hF1E2, 16'h0F0F,
                                         16'h7777, 16'h1FF1, 16'hC3A5};

    logic        clk       = 1'b0;
    logic        rst_n     = 1'b0;
    logic        step_tick = 1'b0;
    logic        uv_off    = 1'b0;
    logic [15:0] duty_code = '0;
    logic [3:0]  oc_trip   = '0;
    wire  [3:0]  drive;
    wire  [3:0]  pwm_rise;
    wire  [3:0]  pwm_fall;

    int checks = 0;
    int fails  = 0;
    int bc     = 0;
    int rise_tot [4] = '{default: 0};
    int fall_tot [4] = '{default: 0};
    int multi_edge = 0;
    int rs [4];
    int fs [4];
    logic [15:0] act_code = '0;

    stag_pwm_quad dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .uv_off    (uv_off),
        .duty_code (duty_code),
        .oc_trip   (oc_trip),
        .drive     (drive),
        .pwm_rise  (pwm_rise),
        .pwm_fall  (pwm_fall)
    );

    always #4 clk = ~clk;

    // Purpose: count strobes per channel and cycles with more than one edge.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 4; k++) begin
                if (pwm_rise[k]) rise_tot[k] = rise_tot[k] + 1;
                if (pwm_fall[k]) fall_tot[k] = fall_tot[k] + 1;
            end
            if ($countones(pwm_rise | pwm_fall) > 1) multi_edge = multi_edge + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected drive pattern, taken from the R2 and R3 requirements.
    function automatic logic [3:0] model(input logic [15:0] code, input int c);
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            int n;
            n = int'(code[4*k +: 4]);
            if (n == 0)          r[k] = 1'b0;
            else if (k % 2 == 1) r[k] = (c >= 16 - n);
            else                 r[k] = (c < n);
        end
        return r;
    endfunction

    // One step tick, followed by enough cycles for all channels to settle.
    task automatic tick();
        @(negedge clk) step_tick = 1'b1;
        @(negedge clk) step_tick = 1'b0;
        repeat (8) @(negedge clk);
        bc = (bc + 1) % 16;
        if (bc == 0) act_code = duty_code;
    endtask

    task automatic snap();
        for (int k = 0; k < 4; k++) begin
            rs[k] = rise_tot[k];
            fs[k] = fall_tot[k];
        end
    endtask

    task automatic chk_strobes(input string req);
        for (int k = 0; k < 4; k++) begin
            chk(rise_tot[k] - rs[k] == 1, req, rise_tot[k] - rs[k], 1);
            chk(fall_tot[k] - fs[k] == 1, req, fall_tot[k] - fs[k], 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(drive == 4'h0,    "R9 reset drive", drive, 0);
        chk(pwm_rise == 4'h0, "R9 reset rise",  pwm_rise, 0);
        chk(pwm_fall == 4'h0, "R9 reset fall",  pwm_fall, 0);
        rst_n = 1'b1;

        // First partial period with all codes at 0 (R3).
        repeat (15) begin
            tick();
            chk(drive == 4'h0, "R3 zero code drive", drive, 0);
        end

        // Table walk: R1, R2, R3, R5, R8.
        for (int v = 0; v < NV; v++) begin
            duty_code = VEC[v];
            snap();
            for (int t = 0; t < 16; t++) begin
                tick();
                chk(drive == model(act_code, bc), "R2 R3 R5 drive pattern",
                    drive, model(act_code, bc));
                if (t == 8 && v + 1 < NV) duty_code = VEC[v + 1];
            end
            chk_strobes("R1 R8 one rise and fall per period");
        end
        chk(multi_edge == 0, "R4 no shared edge cycle", multi_edge, 0);

        // R6: overcurrent blanks channel 0 until the period boundary.
        duty_code = 16'h8888;
        tick();
        chk(drive == model(act_code, bc), "R6 pre-trip drive", drive, model(act_code, bc));
        tick();
        tick();
        @(negedge clk) oc_trip = 4'b0001;
        repeat (3) @(negedge clk);
        oc_trip = 4'b0000;
        repeat (3) @(negedge clk);
        chk(drive[0] == 1'b0, "R6 tripped channel low", drive[0], 0);
        chk(drive[2] == 1'b1, "R6 other channel kept", drive[2], 1);
        while (bc != 15) begin
            tick();
            chk(drive == (model(act_code, bc) & 4'b1110), "R6 blank held",
                drive, model(act_code, bc) & 4'b1110);
        end
        tick();
        chk(drive == model(act_code, bc), "R6 blank released at boundary",
            drive, model(act_code, bc));

        // R7: undervoltage forces the drives low and keeps the state.
        while (bc != 12) tick();
        chk(drive == model(act_code, bc), "R7 before uv", drive, model(act_code, bc));
        @(negedge clk) uv_off = 1'b1;
        #1;
        chk(drive == 4'h0, "R7 uv immediate", drive, 0);
        tick();
        chk(drive == 4'h0, "R7 uv held", drive, 0);
        uv_off = 1'b0;
        @(negedge clk);
        chk(drive == model(act_code, bc), "R7 resume pattern", drive, model(act_code, bc));

        // R9: reset in mid-run clears the counter and the codes.
        rst_n = 1'b0;
        duty_code = 16'hFFFF;
        repeat (2) @(negedge clk);
        chk(drive == 4'h0, "R9 mid-run reset drive", drive, 0);
        rst_n = 1'b1;
        bc = 0;
        act_code = 16'h0000;
        tick();
        chk(drive == 4'h0, "R9 codes cleared", drive, 0);

        // R8, R3: code 0 on every channel still yields one strobe pair per period.
        duty_code = 16'h0000;
        while (bc != 15) tick();
        snap();
        for (int t = 0; t < 16; t++) begin
            tick();
            chk(drive == 4'h0, "R3 zero code full period", drive, 0);
        end
        chk_strobes("R8 strobes with code 0");
        chk(multi_edge == 0, "R4 no shared edge cycle at end", multi_edge, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule